// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is one output cell of a sum-of-products programmable logic device. It receives a vector of product-term results from an AND array. It ORs a parameterised number of those terms, counted from the lowest index, into one sum term. Two configuration bits set how that sum reaches the pin: it either goes straight through or passes through a D flip-flop, and it appears either as written or inverted.

A dedicated output-enable product term controls whether the pin is driven. The cell also takes three signals that the whole device shares:
- an asynchronous clear, which forces the register to 0 at once;
- a synchronous preset, which sets the register on the clock edge;
- a power-on reset, which clears the register.

A feedback line returns a signal to the array. In registered mode it carries the inverted register state. In combinational mode it carries the pin level, so the cell can act as an input while its driver is off. A preload port loads the register directly, which lets test sequences start from a known state.

Top module: `plm_out_cell`

## Requirements
- R1: The sum term is the OR of product terms 0 to PT_USED-1 (defaults: PT_USED = 12, PT_MAX = 16). Terms at index PT_USED and above have no effect on the pin or on the feedback.
- R2: Mode bit `cfg_comb` = 0 selects registered mode and 1 selects combinational mode. The mode bit and the polarity bit take effect without a clock edge.
- R3: In combinational mode, `pin_out` equals the sum when `cfg_act_hi` = 1 and the inverted sum when `cfg_act_hi` = 0, in the same cycle as the product-term change.
- R4: In registered mode, the register samples the sum on the rising clock edge. `pin_out` shows the register state when `cfg_act_hi` = 1 and its inverse when `cfg_act_hi` = 0, and it holds between edges.
- R5: A high `arst` clears the register at once, without waiting for a clock edge. While it is high it overrides both preset and preload.
- R6: When `spre` is high at a rising edge, and neither clear nor preload is active, the register becomes 1 whatever the sum is.
- R7: A low `por_n` clears the register, so a registered active-low output with its enable high reads 1 after power-up.
- R8: `pin_oe` follows `oe_term`. While it is 0, `pin_out` is 0 in both modes.
- R9: `fb_out` is the inverted register state in registered mode. In combinational mode it is the pin level: `pin_out` when the enable is high, and `pin_in` when it is low.
- R10: When `preload_en` is high at a rising edge, the register takes `preload_val`. Preload has priority over preset and over the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| arst | input | 1 | Shared asynchronous clear term, active high |
| spre | input | 1 | Shared synchronous preset term, active high |
| pt_vec | input | PT_MAX | Product-term results from the AND array |
| oe_term | input | 1 | Output-enable product term |
| cfg_comb | input | 1 | Mode bit: 0 registered, 1 combinational |
| cfg_act_hi | input | 1 | Polarity bit: 1 active high, 0 active low |
| preload_en | input | 1 | Load `preload_val` into the register on the next edge |
| preload_val | input | 1 | Value to preload |
| pin_in | input | 1 | Level seen on the pin from outside when not driven |
| pin_out | output | 1 | Pin data (0 while not enabled) |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback into the array |

## Verification
Assertions check the following on every cycle:
- clear dominance over the register;
- the effect of preset and of preload on the next edge;
- sum capture in registered mode;
- the match between the combinational pin and the used product terms;
- the inverse relation between the pin and the feedback in registered mode.

Some behaviours show only in the bench's scenarios:
- the pin level right after power-up with active-low polarity;
- that terms above the used count are ignored;
- that `pin_in` reaches the feedback only when the enable is low;
- that a mode change alters the pin with no clock edge.

// File: rtl/plm_cell_pkg.sv
package plm_cell_pkg;

    typedef enum logic {
        MODE_REG  = 1'b0,
        MODE_COMB = 1'b1
    } cell_mode_e;

    typedef struct packed {
        logic q;
    } cell_state_t;

endpackage

// File: rtl/plm_sum_term.sv
module plm_sum_term #(
    parameter int PT_MAX  = 16,
    parameter int PT_USED = 12
) (
    input  logic [PT_MAX-1:0] pt_vec,
    output logic              sum
);
    logic [PT_MAX-1:0] use_mask;

    // Terms above the used count are tied off inside the mask.
    for (genvar i = 0; i < PT_MAX; i++) begin : g_mask
        if (i < PT_USED) begin : g_on
            assign use_mask[i] = 1'b1;
        end else begin : g_off
            assign use_mask[i] = 1'b0;
        end
    end

    assign sum = |(pt_vec & use_mask);
endmodule

// File: rtl/plm_cell_reg.sv
module plm_cell_reg
    import plm_cell_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic arst,
    input  logic spre,
    input  logic preload_en,
    input  logic preload_val,
    input  logic sum,
    output logic q
);
    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (preload_en)  st_d.q = preload_val;
        else if (spre)   st_d.q = 1'b1;
        else             st_d.q = sum;
    end

    always_ff @(posedge clk or negedge por_n or posedge arst) begin
        if (!por_n || arst) st_q <= '0;
        else                st_q <= st_d;
    end

    assign q = st_q.q;

    // R5: clear dominates whenever it is high at an edge
    a_r5_clear_holds: assert property (@(posedge clk) disable iff (!por_n)
        arst |-> !st_q.q);

    // R6: preset without preload forces a 1
    a_r6_preset_sets: assert property (@(posedge clk) disable iff (!por_n || arst)
        (spre && !preload_en) |=> st_q.q);

    // R10: preload value is taken on the edge
    a_r10_preload_loads: assert property (@(posedge clk) disable iff (!por_n || arst)
        preload_en |=> (st_q.q == $past(preload_val)));

    // R4: plain capture of the sum
    a_r4_sum_capture: assert property (@(posedge clk) disable iff (!por_n || arst)
        (!spre && !preload_en) |=> (st_q.q == $past(sum)));
endmodule

// File: rtl/plm_out_mux.sv
module plm_out_mux
    import plm_cell_pkg::*;
(
    input  cell_mode_e mode,
    input  logic       act_hi,
    input  logic       sum,
    input  logic       q,
    input  logic       oe_term,
    input  logic       pin_in,
    output logic       pin_out,
    output logic       pin_oe,
    output logic       fb_out
);
    logic src;
    logic data;

    always_comb begin
        src     = (mode == MODE_COMB) ? sum : q;
        data    = act_hi ? src : ~src;
        pin_oe  = oe_term;
        pin_out = oe_term & data;
        if (mode == MODE_REG) fb_out = ~q;
        else                  fb_out = oe_term ? data : pin_in;
    end
endmodule

// File: rtl/plm_out_cell.sv
module plm_out_cell
    import plm_cell_pkg::*;
#(
    parameter int PT_MAX  = 16,
    parameter int PT_USED = 12
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              arst,
    input  logic              spre,
    input  logic [PT_MAX-1:0] pt_vec,
    input  logic              oe_term,
    input  logic              cfg_comb,
    input  logic              cfg_act_hi,
    input  logic              preload_en,
    input  logic              preload_val,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              fb_out
);
    localparam int UsedW = (PT_USED < PT_MAX) ? PT_USED : PT_MAX;

    logic       sum;
    logic       q;
    cell_mode_e mode;

    assign mode = cell_mode_e'(cfg_comb);

    plm_sum_term #(.PT_MAX(PT_MAX), .PT_USED(UsedW)) u_sum (
        .pt_vec (pt_vec),
        .sum    (sum)
    );

    plm_cell_reg u_reg (
        .clk         (clk),
        .por_n       (por_n),
        .arst        (arst),
        .spre        (spre),
        .preload_en  (preload_en),
        .preload_val (preload_val),
        .sum         (sum),
        .q           (q)
    );

    plm_out_mux u_mux (
        .mode    (mode),
        .act_hi  (cfg_act_hi),
        .sum     (sum),
        .q       (q),
        .oe_term (oe_term),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .fb_out  (fb_out)
    );

    // R3: an enabled active-high combinational pin tracks the used terms
    a_r3_comb_follows: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_comb && cfg_act_hi && oe_term) |-> (pin_out == |pt_vec[UsedW-1:0]));

    // R9: an enabled active-high registered pin is the inverse of the feedback
    a_r9_fb_inverse: assert property (@(posedge clk) disable iff (!por_n)
        (!cfg_comb && cfg_act_hi && oe_term) |-> (fb_out == !pin_out));

    // R8: no data while the driver is off
    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!por_n)
        !pin_oe |-> !pin_out);
endmodule

// File: tb/plm_out_cell_tb.sv
module plm_out_cell_tb;
    localparam int PT_MAX  = 16;
    localparam int PT_USED = 12;

    logic              clk = 1'b0;
    logic              por_n, arst, spre, oe_term, cfg_comb, cfg_act_hi;
    logic              preload_en, preload_val, pin_in;
    logic [PT_MAX-1:0] pt_vec;
    logic              pin_out, pin_oe, fb_out;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    plm_out_cell #(.PT_MAX(PT_MAX), .PT_USED(PT_USED)) u_dut (
        .clk(clk), .por_n(por_n), .arst(arst), .spre(spre), .pt_vec(pt_vec),
        .oe_term(oe_term), .cfg_comb(cfg_comb), .cfg_act_hi(cfg_act_hi),
        .preload_en(preload_en), .preload_val(preload_val), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
    );

    // {comb, act_hi, oe, pin_in, pt[15:0], exp_pin_out, exp_fb}
    localparam logic [21:0] VEC [10] = '{
        {4'b1110, 16'h0001, 2'b11},
        {4'b1110, 16'h0000, 2'b00},
        {4'b1010, 16'h0000, 2'b11},
        {4'b1010, 16'h0800, 2'b00},
        {4'b1110, 16'hF000, 2'b00},
        {4'b1010, 16'hF000, 2'b11},
        {4'b1101, 16'h0010, 2'b01},
        {4'b1100, 16'h0010, 2'b00},
        {4'b1001, 16'h0000, 2'b01},
        {4'b1111, 16'h0400, 2'b11}
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        por_n = 1'b0; arst = 1'b0; spre = 1'b0; oe_term = 1'b1;
        cfg_comb = 1'b0; cfg_act_hi = 1'b0; preload_en = 1'b0;
        preload_val = 1'b0; pin_in = 1'b0; pt_vec = '0;
        #12;
        // R7: active-low registered output comes up high
        check("R7 por pin", pin_out, 1'b1);
        check("R9 por fb", fb_out, 1'b1);
        @(negedge clk);
        por_n = 1'b1;

        // Combinational table: R1 R3 R8 R9
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            cfg_comb   = VEC[i][21];
            cfg_act_hi = VEC[i][20];
            oe_term    = VEC[i][19];
            pin_in     = VEC[i][18];
            pt_vec     = VEC[i][17:2];
            #1;
            check("R3/R1 table pin", pin_out, VEC[i][1]);
            check("R9 table fb", fb_out, VEC[i][0]);
            check("R8 table oe", pin_oe, VEC[i][19]);
        end

        // Registered mode, active high: R4
        @(negedge clk);
        cfg_comb = 1'b0; cfg_act_hi = 1'b1; oe_term = 1'b1; pin_in = 1'b0;
        pt_vec = 16'h0001;
        tick();
        check("R4 capture 1", pin_out, 1'b1);
        check("R9 reg fb", fb_out, 1'b0);
        pt_vec = 16'h0000;
        #1;
        check("R4 hold between edges", pin_out, 1'b1);
        tick();
        check("R4 capture 0", pin_out, 1'b0);
        pt_vec = 16'h2000;
        tick();
        check("R1 unused term in reg mode", pin_out, 1'b0);

        // R6 preset
        pt_vec = 16'h0000; spre = 1'b1;
        tick();
        check("R6 preset", pin_out, 1'b1);
        spre = 1'b0;

        // R5 async clear, then dominance over preset
        arst = 1'b1;
        #1;
        check("R5 clear without edge", pin_out, 1'b0);
        spre = 1'b1; pt_vec = 16'h0001;
        tick();
        check("R5 clear beats preset", pin_out, 1'b0);
        arst = 1'b0; spre = 1'b0; pt_vec = 16'h0000;

        // R10 preload
        preload_en = 1'b1; preload_val = 1'b1;
        tick();
        check("R10 preload 1", pin_out, 1'b1);
        preload_val = 1'b0; spre = 1'b1; pt_vec = 16'h0001;
        tick();
        check("R10 preload beats preset", pin_out, 1'b0);
        preload_en = 1'b0; spre = 1'b0;

        // R8 enable off in registered mode
        tick();
        oe_term = 1'b0;
        #1;
        check("R8 reg off pin", pin_out, 1'b0);
        check("R8 reg off oe", pin_oe, 1'b0);
        check("R9 reg fb with oe off", fb_out, 1'b0);
        oe_term = 1'b1;

        // R4 active-low view of stored 1
        cfg_act_hi = 1'b0;
        #1;
        check("R4 active low", pin_out, 1'b0);

        // R2 mode switch takes effect with no edge
        cfg_act_hi = 1'b1; pt_vec = 16'h0000;
        cfg_comb = 1'b1;
        #0.5;
        check("R2 switch to comb", pin_out, 1'b0);
        cfg_comb = 1'b0;
        #0.5;
        check("R2 switch back to reg", pin_out, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule